// File: doc/BRIEF.md
# Programmable Logic Macrocell with Dual Configurable Registers

This block is a single output cell of a sum-of-products programmable logic device. The AND array outside it evaluates the product terms. The cell receives twelve logic terms and five control terms: a clear and a clock for each of its two registers, and an output enable. It ORs the logic terms into three four-term sums. Under configuration these three sums can collapse into one twelve-term sum with no added logic level. The sums feed two registers. Each register runs as a D-type or a T-type, and each takes its clock either from its own clock term or from the shared device clock pin.

The first register, or the merged or third sum taken combinationally, drives the output pin. The pin's enable comes from the enable term. The cell returns six signals to the global routing bus: the second-register feedback, the first register and the pin level, each in true and complement form. The second-register feedback can carry either that register's output or its data input, which gives a combinational path back into the array. A synchronous preset shared with neighbouring cells, a power-up clear and a test preload complete the register control.

Clock-term and pin-clock edges are found by sampling on the core clock `clk`, so the whole cell sits in one synchronous domain. Only the clears act at once.

Top module: `pld_macrocell`

## Requirements
- R1: With merging off, register 1 takes the OR of `pt_logic[3:0]`, register 2 takes the OR of `pt_logic[7:4]`, and the combinational output sum is the OR of `pt_logic[11:8]`.
- R2: With `cfg[4]` = 1 (merge), the OR of all twelve logic terms replaces both the register 1 input and the combinational output sum.
- R3: With `cfg[0]` = 0 (register 1) or `cfg[1]` = 0 (register 2), the register loads its sum on its active edge.
- R4: With `cfg[0]` = 1 or `cfg[1]` = 1, the register inverts on its active edge when its sum is 1 and holds when the sum is 0.
- R5: The active edge of a register is a 0-to-1 change of its clock source between two `clk` rising edges. The source is `pt_clk1`/`pt_clk2`, or `clk_pin` when `cfg[2]` (register 1) or `cfg[3]` (register 2) is 1. With no active edge, no preload and no clear, the register holds.
- R6: `pt_rst1` clears register 1 and `pt_rst2` clears register 2 at once, without waiting for `clk`. Each clear leaves the other register unchanged.
- R7: `sync_preset` sets a register to 1 on that register's active edge. A clear overrides it, and it overrides the D/T logic.
- R8: `bus_fb[5]` is register 2's sum input when `cfg[5]` = 1 and register 2's output when `cfg[5]` = 0.
- R9: `bus_fb` = {F2, ~F2, Q1, ~Q1, pin_in, ~pin_in}, with bit 5 first.
- R10: `pad_oe` follows `pt_oe`. `pad_out` is the combinational output sum when `cfg[6]` = 1 and register 1 when `cfg[6]` = 0.
- R11: While `preload_en` is 1, each register loads its `preload_q` bit on every `clk` rising edge, whatever its clock source. A clear overrides the preload.
- R12: `rst_n` low clears both registers and both edge histories, so `bus_fb` reads 6'b010101 when all inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core sampling clock |
| rst_n | input | 1 | power-up clear, active low |
| clk_pin | input | 1 | dedicated device clock pin |
| pt_logic | input | 12 | logic product terms, three groups of four |
| pt_rst1 | input | 1 | clear term for register 1 |
| pt_clk1 | input | 1 | clock term for register 1 |
| pt_rst2 | input | 1 | clear term for register 2 |
| pt_clk2 | input | 1 | clock term for register 2 |
| pt_oe | input | 1 | output-enable term |
| sync_preset | input | 1 | shared synchronous preset |
| pin_in | input | 1 | level sensed on the output pin |
| preload_en | input | 1 | test preload strobe |
| preload_q | input | 2 | preload values, bit 0 register 1, bit 1 register 2 |
| cfg | input | 7 | static configuration word (fields in R2 to R10) |
| pad_out | output | 1 | output pin data |
| pad_oe | output | 1 | output pin enable |
| bus_fb | output | 6 | true/complement feedback to the global bus |

## Verification
Single-term stimulus shows which group of four reaches which consumer, and separates a merged sum from an unmerged one. Clock terms held high across several edges show that edges trigger the registers and levels do not. A clock pulse on the unselected source shows that the clock-source bit really chooses. Clear, preset and preload are asserted in the same cycle as an edge to show their priority. Random terms are then run under all 128 configuration words against a behavioural model, which tells D mode from T mode and register feedback from input feedback in every mix.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int TERMS_PER_SUM = 4,
  parameter int NUM_SUMS = 3,
  localparam int PT_W = TERMS_PER_SUM * NUM_SUMS,
  localparam int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_pin,
  input  logic [PT_W-1:0]  pt_logic,
  input  logic             pt_rst1,
  input  logic             pt_clk1,
  input  logic             pt_rst2,
  input  logic             pt_clk2,
  input  logic             pt_oe,
  input  logic             sync_preset,
  input  logic             pin_in,
  input  logic             preload_en,
  input  logic [1:0]       preload_q,
  input  logic [CFG_W-1:0] cfg,
  output logic             pad_out,
  output logic             pad_oe,
  output logic [5:0]       bus_fb
);
  localparam int CFG_TMODE = 0;
  localparam int CFG_PINCLK = 2;
  localparam int CFG_MERGE = 4;
  localparam int CFG_F2IN = 5;
  localparam int CFG_COMB = 6;

  logic [NUM_SUMS-1:0] sums;
  logic                merged, comb_sum, f2;
  logic [1:0]          ff_in, arst, ptclk, q;

  for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
    assign sums[g] = |pt_logic[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  assign merged   = |sums;
  assign ff_in[0] = cfg[CFG_MERGE] ? merged : sums[0];
  assign ff_in[1] = sums[1];
  assign comb_sum = cfg[CFG_MERGE] ? merged : sums[NUM_SUMS-1];
  assign arst     = {pt_rst2, pt_rst1};
  assign ptclk    = {pt_clk2, pt_clk1};

  for (genvar i = 0; i < 2; i++) begin : g_ff
    logic src, src_d, clr_n, qr;
    assign src   = cfg[CFG_PINCLK+i] ? clk_pin : ptclk[i];
    assign clr_n = rst_n & ~arst[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) src_d <= 1'b0;
      else        src_d <= src;

    always_ff @(posedge clk or negedge clr_n)
      if (!clr_n)                qr <= 1'b0;
      else if (preload_en)       qr <= preload_q[i];
      else if (src && !src_d) begin
        if (sync_preset)         qr <= 1'b1;
        else if (cfg[CFG_TMODE+i]) qr <= qr ^ ff_in[i];
        else                     qr <= ff_in[i];
      end

    assign q[i] = qr;
  end

  assign f2      = cfg[CFG_F2IN] ? ff_in[1] : q[1];
  assign pad_out = cfg[CFG_COMB] ? comb_sum : q[0];
  assign pad_oe  = pt_oe;
  assign bus_fb  = {f2, ~f2, q[0], ~q[0], pin_in, ~pin_in};
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int PT_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_pin,
  input logic [PT_W-1:0] pt_logic,
  input logic            pt_rst1,
  input logic            pt_clk1,
  input logic            sync_preset,
  input logic            preload_en,
  input logic [1:0]      preload_q,
  input logic [6:0]      cfg,
  input logic            q1
);
  logic src1, d1;
  assign src1 = cfg[2] ? clk_pin : pt_clk1;
  assign d1   = cfg[4] ? (pt_logic != '0) : (pt_logic[3:0] != 4'd0);

  AST_Q1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && !pt_rst1 && !(src1 && !$past(src1))) |=> (q1 == $past(q1)) || pt_rst1); // R5

  AST_RST1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rst1 |-> !q1); // R6

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (src1 && !$past(src1) && sync_preset && !preload_en && !pt_rst1) |=> q1 || pt_rst1); // R7

  AST_D_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (src1 && !$past(src1) && !sync_preset && !preload_en && !pt_rst1 && !cfg[0])
      |=> (q1 == $past(d1)) || pt_rst1); // R3

  AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !pt_rst1) |=> (q1 == $past(preload_q[0])) || pt_rst1); // R11
endmodule

bind pld_macrocell pld_macrocell_chk #(.PT_W(PT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_pin(clk_pin), .pt_logic(pt_logic),
  .pt_rst1(pt_rst1), .pt_clk1(pt_clk1), .sync_preset(sync_preset),
  .preload_en(preload_en), .preload_q(preload_q), .cfg(cfg), .q1(q[0])
);

// File: tb/pld_macrocell_tb_top.sv
module pld_macrocell_tb_top;
  logic clk = 0, rst_n = 0, clk_pin = 0;
  logic [11:0] pt_logic = 0;
  logic pt_rst1 = 0, pt_clk1 = 0, pt_rst2 = 0, pt_clk2 = 0, pt_oe = 0;
  logic sync_preset = 0, pin_in = 0, preload_en = 0;
  logic [1:0] preload_q = 0;
  logic [6:0] cfg = 0;
  logic pad_out, pad_oe;
  logic [5:0] bus_fb;

  int errors = 0, total = 0;
  bit done = 0;
  bit m_q1 = 0, m_q2 = 0, m_p1 = 0, m_p2 = 0;

  always #10 clk = ~clk;

  pld_macrocell dut_i (.*);

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    total++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic bit any_in(int lo, int hi);
    for (int b = lo; b <= hi; b++) if (pt_logic[b]) return 1;
    return 0;
  endfunction

  function automatic bit m_in1();
    return cfg[4] ? any_in(0, 11) : any_in(0, 3);
  endfunction

  function automatic bit m_comb();
    return cfg[4] ? any_in(0, 11) : any_in(8, 11);
  endfunction

  function automatic bit next_q(bit q, bit d, bit tmode);
    if (sync_preset) return 1;
    if (tmode) return d ? !q : q;
    return d;
  endfunction

  task automatic m_async();
    if (pt_rst1) m_q1 = 0;
    if (pt_rst2) m_q2 = 0;
  endtask

  task automatic m_edge();
    bit s1, s2;
    s1 = cfg[2] ? clk_pin : pt_clk1;
    s2 = cfg[3] ? clk_pin : pt_clk2;
    if (pt_rst1) m_q1 = 0;
    else if (preload_en) m_q1 = preload_q[0];
    else if (s1 && !m_p1) m_q1 = next_q(m_q1, m_in1(), cfg[0]);
    if (pt_rst2) m_q2 = 0;
    else if (preload_en) m_q2 = preload_q[1];
    else if (s2 && !m_p2) m_q2 = next_q(m_q2, any_in(4, 7), cfg[1]);
    m_p1 = s1;
    m_p2 = s2;
  endtask

  task automatic compare(string tag);
    bit f2;
    f2 = cfg[5] ? any_in(4, 7) : m_q2;
    chk({tag, " bus"}, bus_fb, {f2, !f2, m_q1, !m_q1, pin_in, !pin_in});
    chk({tag, " pad"}, {4'd0, pad_oe, pad_out}, {4'd0, pt_oe, cfg[6] ? m_comb() : m_q1});
  endtask

  task automatic tick();
    m_async(); #1; compare("R9/R10 pre-edge");
    @(posedge clk); m_edge();
    @(negedge clk); m_async(); #1; compare("R9/R10 post-edge");
  endtask

  task automatic pulse1();
    pt_clk1 = 1; tick(); pt_clk1 = 0; tick();
  endtask

  task automatic pulse2();
    pt_clk2 = 1; tick(); pt_clk2 = 0; tick();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R12 reset bus", bus_fb, 6'b010101);
    chk("R12 reset pad", {pad_oe, pad_out}, 2'b00);

    // R1 group steering
    pt_logic = 12'h010; tick();
    pt_clk1 = 1; pt_clk2 = 1; tick(); pt_clk1 = 0; pt_clk2 = 0; tick();
    chk("R1 q2 from group 1", bus_fb[5], 1);
    chk("R1 q1 ignores group 1", bus_fb[3], 0);

    // R2 merge
    cfg = 7'h10; pt_logic = 12'h100; pulse1();
    chk("R2 merged sum into q1", bus_fb[3], 1);
    cfg = 7'h40; pt_logic = 12'h001; tick();
    chk("R10 comb output uses group 2", pad_out, 0);
    cfg = 7'h50; tick();
    chk("R2 merged comb output", pad_out, 1);

    // R4 / R3
    cfg = 7'h01; pt_logic = 12'h001; pulse1();
    chk("R4 toggle to 0", bus_fb[3], 0);
    pulse1();
    chk("R4 toggle to 1", bus_fb[3], 1);
    pt_logic = 0; pulse1();
    chk("R4 hold with sum 0", bus_fb[3], 1);
    cfg = 7'h00; pulse1();
    chk("R3 D loads 0", bus_fb[3], 0);

    // R5 edges and clock source
    pt_logic = 12'h001; pt_clk1 = 1; tick();
    chk("R5 rising edge loads", bus_fb[3], 1);
    pt_logic = 0; tick(); tick();
    chk("R5 held level no load", bus_fb[3], 1);
    pt_clk1 = 0; tick();
    cfg = 7'h04; pulse1();
    chk("R5 unselected term clock ignored", bus_fb[3], 1);
    clk_pin = 1; tick(); clk_pin = 0; tick();
    chk("R5 pin clock loads", bus_fb[3], 0);

    // R6 independent clears
    cfg = 0; pt_logic = 12'h011; pulse1(); pulse2();
    pt_rst1 = 1; tick();
    chk("R6 clear q1", bus_fb[3], 0);
    chk("R6 q2 untouched", bus_fb[5], 1);
    pt_rst1 = 0; tick();

    // R7 preset priority
    pt_logic = 0; sync_preset = 1; pulse1();
    chk("R7 preset sets q1", bus_fb[3], 1);
    pt_rst1 = 1; pt_clk1 = 1; tick();
    chk("R7 clear beats preset", bus_fb[3], 0);
    pt_rst1 = 0; pt_clk1 = 0; sync_preset = 0; tick();

    // R8 feedback select
    cfg = 7'h20; pt_logic = 0; tick();
    chk("R8 input feedback 0", bus_fb[5:4], 2'b01);
    pt_logic = 12'h010; tick();
    chk("R8 input feedback 1", bus_fb[5:4], 2'b10);
    cfg = 0; pt_logic = 0; tick();
    chk("R8 register feedback", bus_fb[5], 1);

    // R9 pin feedback
    pin_in = 1; tick();
    chk("R9 pin pair", bus_fb[1:0], 2'b10);

    // R11 preload
    preload_en = 1; preload_q = 2'b01; tick();
    chk("R11 preload", {bus_fb[5], bus_fb[3]}, 2'b01);
    preload_q = 2'b10; tick();
    chk("R11 preload swap", {bus_fb[5], bus_fb[3]}, 2'b10);
    preload_en = 0; tick();

    // R10 enable and registered output
    pt_oe = 1; tick();
    chk("R10 oe and q1 out", {pad_oe, pad_out}, 2'b10);

    // all configurations against the model
    for (int c = 0; c < 128; c++) begin
      cfg = c[6:0];
      for (int k = 0; k < 30; k++) begin
        pt_logic = 12'($urandom);
        pt_clk1 = 1'($urandom); pt_clk2 = 1'($urandom); clk_pin = 1'($urandom);
        pt_rst1 = ($urandom % 16) == 0; pt_rst2 = ($urandom % 16) == 0;
        sync_preset = ($urandom % 4) == 0;
        preload_en = ($urandom % 16) == 0; preload_q = 2'($urandom);
        pt_oe = 1'($urandom); pin_in = 1'($urandom);
        tick();
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule